// File: doc/BRIEF.md
# Set-Associative Address Translation Lookup

This block turns a 32-bit virtual address into a physical address through a small set-associative translation buffer that it holds itself. Pages are 4 KiB: the upper 20 bits of the virtual address form the page number, and the low 12 bits pass through unchanged as the offset. A lookup request carries the address and the current process identifier. The block reads every way of the selected set at once and returns, one cycle later, a hit flag, the physical address, the cached flag and the read/write/execute permissions.

A separate controller fills entries through a write port addressed by way and set. It inspects them through a combinational read port addressed the same way. Each entry holds a 32-bit tag word and a data word. In the tag word, the page number is in bits 31:12, the global flag in bit 11, the valid flag in bit 10 and the process identifier in the low `PID_W` bits. The data word holds a 20-bit frame number and the cached, read, write and execute flags. The way count, the total entry count and the identifier width are parameters. Both counts must be powers of two, and `PID_W` must not exceed 10.

Top module: `tlb_lookup_unit`

## Requirements
- R1: After reset `rsp_valid` and `rsp_hit` are 0, and every entry is invalid, so a lookup of any address misses.
- R2: The set index is the page number (`lk_vaddr >> 12`) ANDed with (entries / ways) − 1.
- R3: A way hits when its stored page number equals the lookup page number, and either its global bit (tag bit 11) is set or its stored identifier (tag bits PID_W−1:0) equals `lk_pid`.
- R4: An entry whose valid bit (tag bit 10) is 0 never hits, even when every other field matches.
- R5: On a hit, `rsp_paddr` is the frame number shifted left by 12, ORed with `lk_vaddr[11:0]`. On a miss, `rsp_paddr` and all the flag outputs are 0.
- R6: On a hit, `rsp_cache`, `rsp_rd`, `rsp_wr` and `rsp_ex` equal the stored C, R, W and X flags of the hitting entry.
- R7: When several ways of a set hit, the lowest-numbered way supplies the result.
- R8: `rsp_valid` is 1 exactly in the cycle after a cycle with `lk_req` high. Outside a response, `rsp_hit`, `rsp_paddr` and the flag outputs are 0.
- R9: A write with `wr_en` high stores the tag and data at (`wr_way`, `wr_set`). From the next cycle on, the read port returns them for that way and set.
- R10: A lookup in the same cycle as a write sees the contents as they were before the write.
- R11: Entries in the same set but different ways coexist: each one hits for its own page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request for this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | PID_W | Current process identifier |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Translation found |
| rsp_paddr | output | 32 | Physical address |
| rsp_cache | output | 1 | Cached flag of the hitting entry |
| rsp_rd | output | 1 | Read permission |
| rsp_wr | output | 1 | Write permission |
| rsp_ex | output | 1 | Execute permission |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | log2(NUM_WAYS) | Way written |
| wr_set | input | log2(entries/ways) | Set written |
| wr_tag | input | 32 | Tag word written |
| wr_pfn | input | 20 | Frame number written |
| wr_flags | input | 4 | C, R, W, X flags written (bit 3 down to bit 0) |
| rd_way | input | log2(NUM_WAYS) | Way inspected |
| rd_set | input | log2(entries/ways) | Set inspected |
| rd_tag | output | 32 | Tag word of the inspected entry |
| rd_pfn | output | 20 | Frame number of the inspected entry |
| rd_flags | output | 4 | C, R, W, X flags of the inspected entry |

## Verification
The bench builds the block with four ways, 32 entries (eight sets) and an 8-bit identifier. With only eight sets, page numbers 0x03 and 0x13 alias to the same set, so several ways of one set can be filled and made to hit together. This exercises the lowest-way priority and the coexistence of aliased entries. The small identifier range used in the random phase makes private and global entries collide often. Same-cycle write and lookup traffic is also frequent.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;
  localparam int PAGE_BITS = 12;
  localparam int VPN_W     = 20;
  localparam int PFN_W     = 20;
  localparam int TAG_G_BIT = 11;
  localparam int TAG_V_BIT = 10;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             cch;
    logic             rd;
    logic             wr;
    logic             ex;
  } tlb_data_t;

  function automatic logic [VPN_W-1:0] vpn_of(input logic [31:0] va);
    return va[31:PAGE_BITS];
  endfunction

  function automatic logic [VPN_W-1:0] tag_vpn(input logic [31:0] tag);
    return tag[31:PAGE_BITS];
  endfunction

  function automatic logic [31:0] join_paddr(input logic [PFN_W-1:0] pfn,
                                             input logic [31:0] va);
    return {pfn, va[PAGE_BITS-1:0]};
  endfunction

  function automatic logic page_match(input logic [VPN_W-1:0] stored,
                                      input logic [VPN_W-1:0] probe,
                                      input logic glob, input logic pid_eq,
                                      input logic vld);
    return vld && (stored == probe) && (glob || pid_eq);
  endfunction
endpackage

// File: rtl/tlbl_way_store.sv
module tlbl_way_store #(
  parameter int NUM_SETS = 8,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [SET_W-1:0]    wset,
  input  logic [31:0]         wtag,
  input  tlbl_pkg::tlb_data_t wdata,
  input  logic [SET_W-1:0]    lk_set,
  output logic [31:0]         lk_tag,
  output tlbl_pkg::tlb_data_t lk_data,
  input  logic [SET_W-1:0]    dbg_set,
  output logic [31:0]         dbg_tag,
  output tlbl_pkg::tlb_data_t dbg_data
);
  logic [31:0]         tag_q  [NUM_SETS];
  tlbl_pkg::tlb_data_t data_q [NUM_SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        tag_q[s]  <= '0;
        data_q[s] <= '0;
      end
    end else if (we) begin
      tag_q[wset]  <= wtag;
      data_q[wset] <= wdata;
    end
  end

  assign lk_tag   = tag_q[lk_set];
  assign lk_data  = data_q[lk_set];
  assign dbg_tag  = tag_q[dbg_set];
  assign dbg_data = data_q[dbg_set];
endmodule

// File: rtl/tlbl_way_match.sv
module tlbl_way_match #(
  parameter int PID_W = 8
) (
  input  logic [19:0]      ent_vpn,
  input  logic             ent_glob,
  input  logic             ent_valid,
  input  logic [PID_W-1:0] ent_pid,
  input  logic [19:0]      probe_vpn,
  input  logic [PID_W-1:0] probe_pid,
  output logic             way_hit
);
  logic pid_same;
  assign pid_same = (ent_pid == probe_pid);
  assign way_hit  = tlbl_pkg::page_match(ent_vpn, probe_vpn, ent_glob,
                                         pid_same, ent_valid);

  always_comb begin
    // R4
    if (ent_valid === 1'b0)
      invalid_no_hit_chk: assert (way_hit !== 1'b1);
  end
endmodule

// File: rtl/tlbl_hit_select.sv
module tlbl_hit_select #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic [NUM_WAYS-1:0] hits,
  output logic [NUM_WAYS-1:0] grant,
  output logic                any_hit,
  output logic [WAY_W-1:0]    win_idx
);
  assign grant   = hits & (~hits + NUM_WAYS'(1));
  assign any_hit = |hits;

  always_comb begin
    win_idx = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (hits[w]) win_idx = WAY_W'(w);
  end

  always_comb begin
    // R7
    lowest_way_chk: assert (!any_hit || grant == (NUM_WAYS'(1) << win_idx));
    // R7
    grant_onehot_chk: assert ($onehot0(grant));
  end
endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit #(
  parameter int NUM_WAYS    = 4,
  parameter int NUM_ENTRIES = 32,
  parameter int PID_W       = 8,
  localparam int NUM_SETS = NUM_ENTRIES / NUM_WAYS,
  localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [31:0]      lk_vaddr,
  input  logic [PID_W-1:0] lk_pid,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [31:0]      rsp_paddr,
  output logic             rsp_cache,
  output logic             rsp_rd,
  output logic             rsp_wr,
  output logic             rsp_ex,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [SET_W-1:0] wr_set,
  input  logic [31:0]      wr_tag,
  input  logic [19:0]      wr_pfn,
  input  logic [3:0]       wr_flags,
  input  logic [WAY_W-1:0] rd_way,
  input  logic [SET_W-1:0] rd_set,
  output logic [31:0]      rd_tag,
  output logic [19:0]      rd_pfn,
  output logic [3:0]       rd_flags
);
  import tlbl_pkg::*;

  logic [VPN_W-1:0] probe_vpn;
  logic [SET_W-1:0] probe_set;
  tlb_data_t        wr_data;

  assign probe_vpn = vpn_of(lk_vaddr);
  assign probe_set = probe_vpn[SET_W-1:0];
  assign wr_data   = '{pfn: wr_pfn, cch: wr_flags[3], rd: wr_flags[2],
                       wr: wr_flags[1], ex: wr_flags[0]};

  logic [31:0]   lk_tag_w  [NUM_WAYS];
  tlb_data_t     lk_data_w [NUM_WAYS];
  logic [31:0]   dbg_tag_w [NUM_WAYS];
  tlb_data_t     dbg_data_w[NUM_WAYS];
  logic [NUM_WAYS-1:0] way_hits;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic way_we;
    assign way_we = wr_en && (wr_way == WAY_W'(w));

    tlbl_way_store #(.NUM_SETS(NUM_SETS)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (way_we),
      .wset    (wr_set),
      .wtag    (wr_tag),
      .wdata   (wr_data),
      .lk_set  (probe_set),
      .lk_tag  (lk_tag_w[w]),
      .lk_data (lk_data_w[w]),
      .dbg_set (rd_set),
      .dbg_tag (dbg_tag_w[w]),
      .dbg_data(dbg_data_w[w])
    );

    tlbl_way_match #(.PID_W(PID_W)) u_match (
      .ent_vpn  (tag_vpn(lk_tag_w[w])),
      .ent_glob (lk_tag_w[w][TAG_G_BIT]),
      .ent_valid(lk_tag_w[w][TAG_V_BIT]),
      .ent_pid  (lk_tag_w[w][PID_W-1:0]),
      .probe_vpn(probe_vpn),
      .probe_pid(lk_pid),
      .way_hit  (way_hits[w])
    );
  end

  logic [NUM_WAYS-1:0] grant;
  logic                any_hit;
  logic [WAY_W-1:0]    win_idx;

  tlbl_hit_select #(.NUM_WAYS(NUM_WAYS)) u_sel (
    .hits   (way_hits),
    .grant  (grant),
    .any_hit(any_hit),
    .win_idx(win_idx)
  );

  tlb_data_t win_data;
  logic      take_hit;
  assign win_data = lk_data_w[win_idx];
  assign take_hit = lk_req && any_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_cache <= 1'b0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_ex    <= 1'b0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= take_hit;
      rsp_paddr <= take_hit ? join_paddr(win_data.pfn, lk_vaddr) : '0;
      rsp_cache <= take_hit && win_data.cch;
      rsp_rd    <= take_hit && win_data.rd;
      rsp_wr    <= take_hit && win_data.wr;
      rsp_ex    <= take_hit && win_data.ex;
    end
  end

  assign rd_tag   = dbg_tag_w[rd_way];
  assign rd_pfn   = dbg_data_w[rd_way].pfn;
  assign rd_flags = {dbg_data_w[rd_way].cch, dbg_data_w[rd_way].rd,
                     dbg_data_w[rd_way].wr, dbg_data_w[rd_way].ex};

  // R8
  req_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);
  // R8
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!rsp_valid && !rsp_hit && rsp_paddr == '0));
  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && !rsp_rd && !rsp_wr
                                 && !rsp_ex && !rsp_cache));
  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && any_hit) |=> (rsp_paddr[11:0] == $past(lk_vaddr[11:0])));
endmodule

// File: tb/tlb_lookup_unit_bench.sv
module tlb_lookup_unit_bench;
  localparam int NW = 4, NE = 32, PW = 8, NS = NE / NW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        lk_req = 0;
  logic [31:0] lk_vaddr = 0;
  logic [7:0]  lk_pid = 0;
  logic        rsp_valid, rsp_hit, rsp_cache, rsp_rd, rsp_wr, rsp_ex;
  logic [31:0] rsp_paddr;
  logic        wr_en = 0;
  logic [1:0]  wr_way = 0, rd_way = 0;
  logic [2:0]  wr_set = 0, rd_set = 0;
  logic [31:0] wr_tag = 0;
  logic [19:0] wr_pfn = 0;
  logic [3:0]  wr_flags = 0;
  logic [31:0] rd_tag;
  logic [19:0] rd_pfn;
  logic [3:0]  rd_flags;

  tlb_lookup_unit #(.NUM_WAYS(NW), .NUM_ENTRIES(NE), .PID_W(PW)) u_tlb_lookup_unit (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .rsp_cache(rsp_cache), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex),
    .wr_en(wr_en), .wr_way(wr_way), .wr_set(wr_set), .wr_tag(wr_tag),
    .wr_pfn(wr_pfn), .wr_flags(wr_flags), .rd_way(rd_way), .rd_set(rd_set),
    .rd_tag(rd_tag), .rd_pfn(rd_pfn), .rd_flags(rd_flags));

  int total = 0, bad = 0;
  bit done = 0, live = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model: flat arrays indexed way*NS + (vpn mod NS)
  logic [31:0] m_tag [NE];
  logic [19:0] m_pfn [NE];
  logic [3:0]  m_fl  [NE];
  logic        e_valid = 0, e_hit = 0;
  logic [31:0] e_paddr = 0;
  logic [3:0]  e_fl = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin m_tag[i] = 0; m_pfn[i] = 0; m_fl[i] = 0; end
      e_valid = 0; e_hit = 0; e_paddr = 0; e_fl = 0;
    end else begin
      e_valid = lk_req; e_hit = 0; e_paddr = 0; e_fl = 0;
      if (lk_req) begin
        for (int w = 0; w < NW; w++) begin
          int k;
          logic [31:0] t;
          k = w * NS + int'((lk_vaddr >> 12) % NS);
          t = m_tag[k];
          if (!e_hit && t[10] && (t >> 12) == (lk_vaddr >> 12) &&
              (t[11] || t[7:0] == lk_pid)) begin
            e_hit = 1;
            e_paddr = (32'(m_pfn[k]) << 12) | (lk_vaddr & 32'hFFF);
            e_fl = m_fl[k];
          end
        end
      end
      if (wr_en) begin
        m_tag[int'(wr_way) * NS + int'(wr_set)] = wr_tag;
        m_pfn[int'(wr_way) * NS + int'(wr_set)] = wr_pfn;
        m_fl [int'(wr_way) * NS + int'(wr_set)] = wr_flags;
      end
    end
  end

  always @(negedge clk) begin
    if (live && !done) begin
      check("R8 model valid", 64'(rsp_valid), 64'(e_valid));
      check("R3 model hit", 64'(rsp_hit), 64'(e_hit));
      check("R5 model paddr", 64'(rsp_paddr), 64'(e_paddr));
      check("R6 model flags", 64'({rsp_cache, rsp_rd, rsp_wr, rsp_ex}), 64'(e_fl));
    end
  end

  function automatic logic [31:0] mk_tag(input logic [19:0] vpn, input logic g,
                                         input logic v, input logic [7:0] pid);
    return {vpn, g, v, 2'b00, pid};
  endfunction

  task automatic put(input int way, input int set, input logic [31:0] tag,
                     input logic [19:0] pfn, input logic [3:0] fl);
    wr_en = 1; wr_way = 2'(way); wr_set = 3'(set); wr_tag = tag; wr_pfn = pfn; wr_flags = fl;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] pid);
    lk_req = 1; lk_vaddr = va; lk_pid = pid;
    @(negedge clk);
    lk_req = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check("R1 reset valid", 64'(rsp_valid), 0);
    check("R1 reset hit", 64'(rsp_hit), 0);
    rst_n = 1;
    @(negedge clk);
    live = 1;
    // R1 R4: cleared entries (tag all zero, valid 0) miss even for vpn 0 pid 0
    look(32'h0000_0123, 8'h00);
    check("R1 empty miss", 64'(rsp_hit), 0);
    check("R8 rsp valid", 64'(rsp_valid), 1);
    @(negedge clk);
    check("R8 no req no rsp", 64'(rsp_valid), 0);

    // R9: write then read back
    put(0, 3, mk_tag(20'h00003, 0, 1, 8'h12), 20'hABCDE, 4'b0110);
    rd_way = 0; rd_set = 3; #1;
    check("R9 rd tag", 64'(rd_tag), 64'(mk_tag(20'h00003, 0, 1, 8'h12)));
    check("R9 rd pfn", 64'(rd_pfn), 64'h0ABCDE);
    check("R9 rd flags", 64'(rd_flags), 64'h6);

    // R2 R3 R5 R6: private hit with matching pid
    look(32'h0000_35A4, 8'h12);
    check("R3 private hit", 64'(rsp_hit), 1);
    check("R5 paddr", 64'(rsp_paddr), 64'hABCDE5A4);
    check("R6 flags", 64'({rsp_cache, rsp_rd, rsp_wr, rsp_ex}), 64'h6);
    // R3: other pid misses
    look(32'h0000_35A4, 8'h13);
    check("R3 pid mismatch miss", 64'(rsp_hit), 0);
    check("R5 miss paddr zero", 64'(rsp_paddr), 0);

    // R3: global entry matches any pid
    put(1, 5, mk_tag(20'h10005, 1, 1, 8'h44), 20'h00777, 4'b1001);
    look(32'h1000_5010, 8'h99);
    check("R3 global hit", 64'(rsp_hit), 1);
    check("R5 global paddr", 64'(rsp_paddr), 64'h00777010);
    check("R6 global flags", 64'({rsp_cache, rsp_rd, rsp_wr, rsp_ex}), 64'h9);

    // R4: invalid entry with otherwise matching fields
    put(0, 6, mk_tag(20'h00006, 1, 0, 8'h00), 20'h55555, 4'b1111);
    look(32'h0000_6000, 8'h00);
    check("R4 invalid miss", 64'(rsp_hit), 0);

    // R11 R2: vpn 0x13 aliases set 3 in way 2
    put(2, 3, mk_tag(20'h00013, 0, 1, 8'h12), 20'h11111, 4'b0001);
    look(32'h0001_3ABC, 8'h12);
    check("R11 alias hit", 64'(rsp_paddr), 64'h11111ABC);
    look(32'h0000_3ABC, 8'h12);
    check("R11 original kept", 64'(rsp_paddr), 64'hABCDEABC);

    // R7: duplicate in way 3, lowest way wins
    put(3, 3, mk_tag(20'h00003, 1, 1, 8'h00), 20'h22222, 4'b0100);
    look(32'h0000_3004, 8'h12);
    check("R7 lowest way", 64'(rsp_paddr), 64'hABCDE004);
    look(32'h0000_3004, 8'h01);
    check("R7 only global way", 64'(rsp_paddr), 64'h22222004);

    // R10: write and lookup in one cycle sees old contents
    wr_en = 1; wr_way = 0; wr_set = 3; wr_tag = mk_tag(20'h00003, 0, 1, 8'h12);
    wr_pfn = 20'h33333; wr_flags = 4'b0010;
    lk_req = 1; lk_vaddr = 32'h0000_3008; lk_pid = 8'h12;
    @(negedge clk);
    wr_en = 0; lk_req = 0;
    check("R10 old contents", 64'(rsp_paddr), 64'hABCDE008);
    look(32'h0000_3008, 8'h12);
    check("R10 new contents", 64'(rsp_paddr), 64'h33333008);

    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [19:0] vpn;
      vpn = 20'($urandom_range(0, 15)) | ($urandom_range(0, 3) == 0 ? 20'h80000 : 20'h0);
      lk_req = 1'($urandom_range(0, 1));
      lk_vaddr = {vpn, 12'($urandom)};
      lk_pid = 8'($urandom_range(0, 3));
      wr_en = ($urandom_range(0, 2) == 0);
      vpn = 20'($urandom_range(0, 15));
      wr_way = 2'($urandom);
      wr_set = vpn[2:0];
      wr_tag = mk_tag(vpn, ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) != 0),
                      8'($urandom_range(0, 3)));
      wr_pfn = 20'($urandom);
      wr_flags = 4'($urandom);
      @(negedge clk);
    end
    lk_req = 0; wr_en = 0;
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule